// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This block sits between a word-addressed processor port and a slower main-memory port. It keeps 8K words of recently used data, arranged as 1024 lines of 8 words. Each line has a valid flag and a stored tag. The processor address is split from the top down into a tag, a line index and a word offset. A read that finds its line present and tagged correctly is answered from local storage on the next cycle. A read that misses stalls the processor while the whole 8-word line is fetched from memory one word at a time. The requested word is then returned and the line is marked present.

Stores follow a write-through, no-allocate policy. Every store goes to main memory. A store that hits also updates the cached copy, and a store that misses leaves the cache untouched. A separate snoop input reports writes made to memory by another bus master. When such a write lands in a line that is cached under the same tag, the line is dropped, so the processor never reads stale data afterwards.

Top module: `dm_wt_cache`

## Requirements
- R1: The word offset is address bits [2:0], the line index is bits [12:3] and the tag is bits [19:13]. Memory block n may only occupy line n mod 1024. Two addresses with equal index and different tags displace one another, and addresses with different index never do.
- R2: After reset no line is valid, cpu_ready is 1, and cpu_rvalid and mem_req are 0. The first read of any address is a miss.
- R3: A read hit raises cpu_rvalid with the stored word in the cycle after the request is accepted. It produces no memory request, and cpu_ready stays 1.
- R4: A read miss holds cpu_ready at 0 and issues exactly 8 memory reads with mem_we 0, at word offsets 0 through 7 in that order, all with the request's tag and index. Each read completes on a mem_valid pulse. cpu_rvalid follows one cycle after the last pulse and carries the requested word. The line then hits.
- R5: A write hit updates the cached word and issues one memory write with mem_we 1 carrying the request's address and data. cpu_ready stays 0 until that write's mem_valid. A later read of that word hits and returns the new value.
- R6: A write miss issues one memory write and allocates no line, so a later read of that address misses and fetches the written value from memory.
- R7: A snoop_valid pulse whose address has the index and tag of a valid line invalidates that line, and the next read of the line misses. A snoop with the same index and a different tag leaves the line valid.
- R8: A snoop that matches the line being refilled lets the refill finish and return the requested word, but leaves the line invalid.
- R9: A snoop in the same cycle as an accepted read of the same line turns that read into a miss.
- R10: cpu_rvalid is raised only in answer to reads. A write never produces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, accepted when cpu_ready is 1 |
| cpu_we | input | 1 | 1 for a write request, 0 for a read |
| cpu_addr | input | 20 | Processor word address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_ready | output | 1 | Controller can accept a request this cycle |
| cpu_rvalid | output | 1 | Read data valid pulse |
| cpu_rdata | output | 32 | Read data |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Pending memory access is a write |
| mem_addr | output | 20 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_valid | input | 1 | Memory completes the pending access (read data valid or write done) |
| mem_rdata | input | 32 | Memory read data |
| snoop_valid | input | 1 | An external master wrote memory this cycle |
| snoop_addr | input | 20 | Word address of that external write |

## Verification
An external write can be reported in the same cycle that the processor lookup runs, and it can also be reported during a line refill. For the first case, the bench drives snoop_valid and a read request on the same negative edge, aimed at a line that is already present. It then expects a full 8-beat refill and the post-write value. For the second case, a parallel thread pulses the snoop a few cycles into a refill, aimed at another word of the same line. The bench expects the requested word to come back unchanged, and the next read of the line to refetch it and return the snooped value.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    localparam int DEF_WORD_W     = 32;
    localparam int DEF_ADDR_W     = 20;
    localparam int DEF_LINES      = 1024;
    localparam int DEF_LINE_WORDS = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2
    } dmc_state_e;

    function automatic int tag_bits(input int addr_w, input int lines, input int line_words);
        return addr_w - $clog2(lines) - $clog2(line_words);
    endfunction

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store
    import dmc_pkg::*;
#(
    parameter int TAG_W = 7,
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic             snp_valid,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic             upd_valid
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];
    logic             snp_hit;
    logic             snp_same_cycle;
    logic             snp_clear;

    // A snoop to the looked-up line in the same cycle forces a miss.
    always_comb begin
        snp_same_cycle = snp_valid && (snp_idx == lk_idx) && (snp_tag == lk_tag);
        lk_hit         = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag) && !snp_same_cycle;
        snp_hit        = snp_valid && valid_q[snp_idx] && (tag_q[snp_idx] == snp_tag);
        snp_clear      = snp_hit && !(upd_en && (upd_idx == snp_idx));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            if (upd_en) begin
                valid_q[upd_idx] <= upd_valid;
            end
            if (snp_clear) begin
                valid_q[snp_idx] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (upd_en) begin
            tag_q[upd_idx] <= upd_tag;
        end
    end

    AST_SNOOP_DROPS_LINE: assert property (@(posedge clk) disable iff (rst)
        snp_clear |=> !valid_q[$past(snp_idx)]); // R7

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store
    import dmc_pkg::*;
#(
    parameter int WORD_W     = DEF_WORD_W,
    parameter int LINES      = DEF_LINES,
    parameter int LINE_WORDS = DEF_LINE_WORDS
) (
    input  logic                          clk,
    input  logic [$clog2(LINES)-1:0]      rd_idx,
    input  logic [$clog2(LINE_WORDS)-1:0] rd_off,
    output logic [WORD_W-1:0]             rd_word,
    input  logic                          wr_en,
    input  logic [$clog2(LINES)-1:0]      wr_idx,
    input  logic [$clog2(LINE_WORDS)-1:0] wr_off,
    input  logic [WORD_W-1:0]             wr_word
);
    localparam int LINE_BITS = WORD_W * LINE_WORDS;

    logic [LINE_BITS-1:0] line_q [LINES];

    assign rd_word = line_q[rd_idx][int'(rd_off)*WORD_W +: WORD_W];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_q[wr_idx][int'(wr_off)*WORD_W +: WORD_W] <= wr_word;
        end
    end

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int WORD_W     = DEF_WORD_W,
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int LINES      = DEF_LINES,
    parameter int LINE_WORDS = DEF_LINE_WORDS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cpu_req,
    input  logic                          cpu_we,
    input  logic [ADDR_W-1:0]             cpu_addr,
    input  logic [WORD_W-1:0]             cpu_wdata,
    output logic                          cpu_ready,
    output logic                          cpu_rvalid,
    output logic [WORD_W-1:0]             cpu_rdata,
    input  logic                          lk_hit,
    input  logic [WORD_W-1:0]             rd_word,
    input  logic                          snp_valid,
    input  logic [ADDR_W-1:0]             snp_addr,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [WORD_W-1:0]             mem_wdata,
    input  logic                          mem_valid,
    input  logic [WORD_W-1:0]             mem_rdata,
    output logic                          dw_en,
    output logic [$clog2(LINES)-1:0]      dw_idx,
    output logic [$clog2(LINE_WORDS)-1:0] dw_off,
    output logic [WORD_W-1:0]             dw_data,
    output logic                          upd_en,
    output logic [$clog2(LINES)-1:0]      upd_idx,
    output logic [ADDR_W-$clog2(LINES)-$clog2(LINE_WORDS)-1:0] upd_tag,
    output logic                          upd_valid
);
    localparam int OFF_W = $clog2(LINE_WORDS);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_WORDS - 1);

    dmc_state_e        state_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic [WORD_W-1:0] pend_wdata_q;
    logic [WORD_W-1:0] rdata_q;
    logic [OFF_W-1:0]  beat_q;
    logic              kill_q;
    logic              rvalid_q;

    logic              accept;
    logic              fill_beat;
    logic              last_beat;
    logic              snp_on_pend;
    logic [IDX_W-1:0]  pend_idx;
    logic [TAG_W-1:0]  pend_tag;
    logic [OFF_W-1:0]  pend_off;

    always_comb begin
        pend_off    = pend_addr_q[OFF_W-1:0];
        pend_idx    = pend_addr_q[OFF_W +: IDX_W];
        pend_tag    = pend_addr_q[ADDR_W-1 -: TAG_W];
        accept      = (state_q == ST_IDLE) && cpu_req;
        fill_beat   = (state_q == ST_FILL) && mem_valid;
        last_beat   = fill_beat && (beat_q == LAST_BEAT);
        snp_on_pend = snp_valid && (snp_addr[ADDR_W-1:OFF_W] == pend_addr_q[ADDR_W-1:OFF_W]);
    end

    always_comb begin
        cpu_ready  = (state_q == ST_IDLE);
        cpu_rvalid = rvalid_q;
        cpu_rdata  = rdata_q;
        mem_req    = (state_q != ST_IDLE);
        mem_we     = (state_q == ST_WRITE);
        mem_addr   = (state_q == ST_FILL) ? {pend_addr_q[ADDR_W-1:OFF_W], beat_q} : pend_addr_q;
        mem_wdata  = pend_wdata_q;
    end

    // Storage write port: refill beats, or a store that hits.
    always_comb begin
        dw_en   = fill_beat || (accept && cpu_we && lk_hit);
        dw_idx  = fill_beat ? pend_idx  : cpu_addr[OFF_W +: IDX_W];
        dw_off  = fill_beat ? beat_q    : cpu_addr[OFF_W-1:0];
        dw_data = fill_beat ? mem_rdata : cpu_wdata;
    end

    // Tag/valid update on the closing beat of a refill.
    always_comb begin
        upd_en    = last_beat;
        upd_idx   = pend_idx;
        upd_tag   = pend_tag;
        upd_valid = !(kill_q || snp_on_pend);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            pend_addr_q  <= '0;
            pend_wdata_q <= '0;
            rdata_q      <= '0;
            beat_q       <= '0;
            kill_q       <= 1'b0;
            rvalid_q     <= 1'b0;
        end else begin
            rvalid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (cpu_req) begin
                        pend_addr_q  <= cpu_addr;
                        pend_wdata_q <= cpu_wdata;
                        if (cpu_we) begin
                            state_q <= ST_WRITE;
                        end else if (lk_hit) begin
                            rvalid_q <= 1'b1;
                            rdata_q  <= rd_word;
                        end else begin
                            state_q <= ST_FILL;
                            beat_q  <= '0;
                            kill_q  <= 1'b0;
                        end
                    end
                end
                ST_FILL: begin
                    if (snp_on_pend) begin
                        kill_q <= 1'b1;
                    end
                    if (mem_valid) begin
                        if (beat_q == pend_off) begin
                            rdata_q <= mem_rdata;
                        end
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == LAST_BEAT) begin
                            state_q  <= ST_IDLE;
                            rvalid_q <= 1'b1;
                        end
                    end
                end
                ST_WRITE: begin
                    if (mem_valid) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_HIT_ANSWERS_NEXT: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && cpu_req && !cpu_we && lk_hit) |=> (cpu_rvalid && cpu_ready && !mem_req)); // R3

    AST_MISS_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && cpu_req && !cpu_we && !lk_hit) |=>
            (!cpu_ready && mem_req && !mem_we && (mem_addr[OFF_W-1:0] == '0))); // R4

    AST_BEAT_ORDER: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_valid && (mem_addr[OFF_W-1:0] != LAST_BEAT)) |=>
            (mem_req && !mem_we &&
             (mem_addr[OFF_W-1:0] == OFF_W'($past(mem_addr[OFF_W-1:0]) + 1'b1)) &&
             (mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W])))); // R4

    AST_WRITE_GOES_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && cpu_req && cpu_we) |=>
            (mem_req && mem_we && !cpu_ready &&
             (mem_addr == $past(cpu_addr)) && (mem_wdata == $past(cpu_wdata)))); // R5

    AST_NO_RVALID_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && cpu_req && cpu_we) |=> !cpu_rvalid); // R10

endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache
    import dmc_pkg::*;
#(
    parameter int WORD_W     = DEF_WORD_W,
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int LINES      = DEF_LINES,
    parameter int LINE_WORDS = DEF_LINE_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_valid,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr
);
    localparam int OFF_W = $clog2(LINE_WORDS);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = tag_bits(ADDR_W, LINES, LINE_WORDS);

    logic              lk_hit;
    logic [WORD_W-1:0] rd_word;
    logic              dw_en;
    logic [IDX_W-1:0]  dw_idx;
    logic [OFF_W-1:0]  dw_off;
    logic [WORD_W-1:0] dw_data;
    logic              upd_en;
    logic [IDX_W-1:0]  upd_idx;
    logic [TAG_W-1:0]  upd_tag;
    logic              upd_valid;

    dmc_tag_store #(
        .TAG_W (TAG_W),
        .IDX_W (IDX_W)
    ) u_tags (
        .clk       (clk),
        .rst       (rst),
        .lk_idx    (cpu_addr[OFF_W +: IDX_W]),
        .lk_tag    (cpu_addr[ADDR_W-1 -: TAG_W]),
        .lk_hit    (lk_hit),
        .snp_valid (snoop_valid),
        .snp_idx   (snoop_addr[OFF_W +: IDX_W]),
        .snp_tag   (snoop_addr[ADDR_W-1 -: TAG_W]),
        .upd_en    (upd_en),
        .upd_idx   (upd_idx),
        .upd_tag   (upd_tag),
        .upd_valid (upd_valid)
    );

    dmc_data_store #(
        .WORD_W     (WORD_W),
        .LINES      (LINES),
        .LINE_WORDS (LINE_WORDS)
    ) u_data (
        .clk     (clk),
        .rd_idx  (cpu_addr[OFF_W +: IDX_W]),
        .rd_off  (cpu_addr[OFF_W-1:0]),
        .rd_word (rd_word),
        .wr_en   (dw_en),
        .wr_idx  (dw_idx),
        .wr_off  (dw_off),
        .wr_word (dw_data)
    );

    dmc_ctrl #(
        .WORD_W     (WORD_W),
        .ADDR_W     (ADDR_W),
        .LINES      (LINES),
        .LINE_WORDS (LINE_WORDS)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_ready  (cpu_ready),
        .cpu_rvalid (cpu_rvalid),
        .cpu_rdata  (cpu_rdata),
        .lk_hit     (lk_hit),
        .rd_word    (rd_word),
        .snp_valid  (snoop_valid),
        .snp_addr   (snoop_addr),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_valid  (mem_valid),
        .mem_rdata  (mem_rdata),
        .dw_en      (dw_en),
        .dw_idx     (dw_idx),
        .dw_off     (dw_off),
        .dw_data    (dw_data),
        .upd_en     (upd_en),
        .upd_idx    (upd_idx),
        .upd_tag    (upd_tag),
        .upd_valid  (upd_valid)
    );

    AST_MEM_IDLE_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> !mem_req); // R4

endmodule

// File: tb/sim_dm_wt_cache.sv
`timescale 1ns/1ps
module sim_dm_wt_cache;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [19:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic        cpu_rvalid;
    logic [31:0] cpu_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [19:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        snoop_valid = 1'b0;
    logic [19:0] snoop_addr = '0;

    always #2 clk = ~clk;

    dm_wt_cache u0 (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [31:0] ref_mem   [int];
    logic [31:0] mem_store [int];
    int          rd_log[$];
    int          wr_beats;
    logic [19:0] wr_last_addr;
    logic [31:0] wr_last_data;
    bit          exp_valid [1024];
    logic [6:0]  exp_tag   [1024];

    function automatic logic [31:0] init_val(input logic [19:0] a);
        return ({12'h0, a} * 32'h9E3779B1) ^ 32'hA5C30F1E;
    endfunction

    function automatic logic [31:0] ref_rd(input logic [19:0] a);
        if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
        return init_val(a);
    endfunction

    function automatic logic [31:0] mem_rd(input logic [19:0] a);
        if (mem_store.exists(int'(a))) return mem_store[int'(a)];
        return init_val(a);
    endfunction

    function automatic logic [19:0] mk(input logic [6:0] t, input logic [9:0] i, input logic [2:0] o);
        return {t, i, o};
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, expv);
        end
    endtask

    // Behavioural main memory, driven on the falling edge.
    initial begin
        int wait_cnt = 0;
        forever begin
            @(negedge clk);
            mem_valid = 1'b0;
            if (mem_req) begin
                if (wait_cnt == 0) begin
                    wait_cnt = 1 + int'($urandom % 3);
                end else begin
                    wait_cnt--;
                    if (wait_cnt == 0) begin
                        if (mem_we) begin
                            mem_store[int'(mem_addr)] = mem_wdata;
                            wr_beats++;
                            wr_last_addr = mem_addr;
                            wr_last_data = mem_wdata;
                        end else begin
                            mem_rdata = mem_rd(mem_addr);
                            rd_log.push_back(int'(mem_addr));
                        end
                        mem_valid = 1'b1;
                    end
                end
            end else begin
                wait_cnt = 0;
            end
        end
    end

    // External master write: memory and reference change, model line drops.
    task automatic ext_write(input logic [19:0] a, input logic [31:0] v);
        ref_mem[int'(a)]   = v;
        mem_store[int'(a)] = v;
        if (exp_valid[a[12:3]] && exp_tag[a[12:3]] == a[19:13]) exp_valid[a[12:3]] = 1'b0;
    endtask

    task automatic do_snoop(input logic [19:0] a, input logic [31:0] v);
        @(negedge clk);
        snoop_valid = 1'b1;
        snoop_addr  = a;
        ext_write(a, v);
        @(negedge clk);
        snoop_valid = 1'b0;
    endtask

    task automatic do_read(input logic [19:0] a, input bit snp, input logic [19:0] sa,
                           input logic [31:0] sv, output logic [31:0] data, output int lat);
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        rd_log.delete();
        cpu_req  = 1'b1;
        cpu_we   = 1'b0;
        cpu_addr = a;
        if (snp) begin
            snoop_valid = 1'b1;
            snoop_addr  = sa;
            ext_write(sa, sv);
        end
        @(negedge clk);
        cpu_req     = 1'b0;
        snoop_valid = 1'b0;
        lat = 1;
        while (!cpu_rvalid && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        data = cpu_rdata;
    endtask

    task automatic check_refill(input logic [19:0] a, input string rq);
        bit ord = (rd_log.size() == 8);
        check(rd_log.size() == 8, rq, "refill beat count", rd_log.size(), 8);
        if (ord) begin
            for (int k = 0; k < 8; k++) begin
                if (rd_log[k] != int'({a[19:3], 3'(k)})) ord = 0;
            end
        end
        check(ord, rq, "refill addresses in offset order 0..7", ord, 1);
    endtask

    task automatic op_read(input logic [19:0] a, input bit snp, input logic [19:0] sa,
                           input logic [31:0] sv, input string rq);
        logic [31:0] d;
        int lat;
        bit hit;
        do_read(a, snp, sa, sv, d, lat);
        hit = exp_valid[a[12:3]] && exp_tag[a[12:3]] == a[19:13];
        check(d === ref_rd(a), rq, "read data", d, ref_rd(a));
        if (hit) begin
            check(lat == 1, rq, "hit latency", lat, 1);
            check(rd_log.size() == 0, rq, "hit memory reads", rd_log.size(), 0);
        end else begin
            check_refill(a, rq);
            exp_valid[a[12:3]] = 1'b1;
            exp_tag[a[12:3]]   = a[19:13];
        end
    endtask

    task automatic op_write(input logic [19:0] a, input logic [31:0] v, input string rq);
        int rv_seen = 0;
        int guard = 0;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        wr_beats  = 0;
        cpu_req   = 1'b1;
        cpu_we    = 1'b1;
        cpu_addr  = a;
        cpu_wdata = v;
        ref_mem[int'(a)] = v;
        @(negedge clk);
        cpu_req = 1'b0;
        cpu_we  = 1'b0;
        check(cpu_ready == 1'b0, rq, "ready low during write", cpu_ready, 0);
        while (!cpu_ready && guard < 400) begin
            if (cpu_rvalid) rv_seen++;
            @(negedge clk);
            guard++;
        end
        if (cpu_rvalid) rv_seen++;
        check(rv_seen == 0, "R10", "rvalid during write", rv_seen, 0);
        check(wr_beats == 1, rq, "memory write count", wr_beats, 1);
        check(wr_last_addr == a && wr_last_data == v, rq, "memory write address/data",
              wr_last_data, v);
    endtask

    function automatic logic [19:0] rnd_addr();
        logic [6:0] tags [4] = '{7'd0, 7'd1, 7'd2, 7'd127};
        logic [9:0] idxs [4] = '{10'd0, 10'd5, 10'd512, 10'd1023};
        return mk(tags[$urandom % 4], idxs[$urandom % 4], 3'($urandom % 8));
    endfunction

    initial begin
        logic [31:0] d;
        int lat;
        logic [19:0] ea;
        void'($urandom(32'd20190108));
        for (int i = 0; i < 1024; i++) begin
            exp_valid[i] = 1'b0;
            exp_tag[i]   = '0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cpu_ready == 1'b1, "R2", "ready after reset", cpu_ready, 1);
        check(cpu_rvalid == 1'b0, "R2", "rvalid after reset", cpu_rvalid, 0);
        check(mem_req == 1'b0, "R2", "mem_req after reset", mem_req, 0);

        // R2, R4: first access misses; R3: repeat and neighbour hit.
        op_read(mk(7'd1, 10'd5, 3'd3), 0, '0, '0, "R2");
        op_read(mk(7'd1, 10'd5, 3'd3), 0, '0, '0, "R3");
        op_read(mk(7'd1, 10'd5, 3'd6), 0, '0, '0, "R3");

        // R1: same index, other tag displaces; other indices coexist.
        op_read(mk(7'd2, 10'd5, 3'd0), 0, '0, '0, "R1");
        op_read(mk(7'd1, 10'd5, 3'd1), 0, '0, '0, "R1");
        op_read(mk(7'd9, 10'd1023, 3'd7), 0, '0, '0, "R1");
        op_read(mk(7'd9, 10'd0, 3'd0), 0, '0, '0, "R1");
        op_read(mk(7'd9, 10'd1023, 3'd2), 0, '0, '0, "R1");

        // R5: write hit, then hit with new data.
        op_write(mk(7'd1, 10'd5, 3'd4), 32'hCAFE0005, "R5");
        op_read(mk(7'd1, 10'd5, 3'd4), 0, '0, '0, "R5");

        // R6: write miss does not allocate.
        op_write(mk(7'd3, 10'd40, 3'd2), 32'h0BAD0006, "R6");
        op_read(mk(7'd3, 10'd40, 3'd2), 0, '0, '0, "R6");

        // R7: matching snoop drops; non-matching tag leaves line.
        do_snoop(mk(7'd1, 10'd5, 3'd1), 32'h51000001);
        op_read(mk(7'd1, 10'd5, 3'd1), 0, '0, '0, "R7");
        do_snoop(mk(7'd2, 10'd5, 3'd1), 32'h52000002);
        op_read(mk(7'd1, 10'd5, 3'd2), 0, '0, '0, "R7");

        // R8: snoop into the line while it refills.
        ea = mk(7'd4, 10'd77, 3'd2);
        fork
            do_read(ea, 0, '0, '0, d, lat);
            begin
                repeat (4) @(negedge clk);
                snoop_valid = 1'b1;
                snoop_addr  = mk(7'd4, 10'd77, 3'd6);
                ext_write(mk(7'd4, 10'd77, 3'd6), 32'h58000008);
                @(negedge clk);
                snoop_valid = 1'b0;
            end
        join
        check(d === ref_rd(ea), "R8", "requested word during killed refill", d, ref_rd(ea));
        check_refill(ea, "R8");
        exp_valid[10'd77] = 1'b0;
        op_read(mk(7'd4, 10'd77, 3'd6), 0, '0, '0, "R8");

        // R9: snoop in the lookup cycle of a read to a present line.
        op_read(mk(7'd6, 10'd300, 3'd5), 0, '0, '0, "R9");
        op_read(mk(7'd6, 10'd300, 3'd5), 1, mk(7'd6, 10'd300, 3'd5), 32'h59000009, "R9");
        check(rd_log.size() == 8, "R9", "same-cycle snoop forced miss", rd_log.size(), 8);

        // Random mix.
        for (int n = 0; n < 400; n++) begin
            int sel = int'($urandom % 10);
            logic [19:0] ra = rnd_addr();
            if (sel < 5) begin
                bit h = exp_valid[ra[12:3]] && exp_tag[ra[12:3]] == ra[19:13];
                op_read(ra, 0, '0, '0, h ? "R3" : "R4");
            end else if (sel < 8) begin
                bit h = exp_valid[ra[12:3]] && exp_tag[ra[12:3]] == ra[19:13];
                op_write(ra, $urandom, h ? "R5" : "R6");
            end else begin
                do_snoop(ra, $urandom);
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog run did not finish actual=%h expected=%h", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule